// File: doc/BRIEF.md
# SPI Status Flag and Interrupt Controller

This block keeps the four status flags of a serial peripheral interface and turns them into two CPU interrupt requests. A separate shift engine reports events through single-cycle strobes: a byte has arrived, the transmit byte has been moved into the shifter, or a mode fault has been seen. The CPU talks to the block through read and write strobes with a two-bit register select. The flags clear through ordered register accesses, not by writing to the flags.

Each clear sequence starts with a status read, which arms a one-bit state. The matching later access then clears the flag. A new event that arrives before that access cancels the arming, so a flag raised after the status read is never lost. The enable bits come from a control register held outside this block. Gating differs between the two interrupt lines. The transmit request needs the peripheral enable, while the receive request does not. A mode-fault enable decides whether a mode fault can be recorded at all.

Top module: `spi_flag_irq`

## Requirements
- R1: After reset, `status_o` is 4'b0010 (bit 0 receiver full = 0, bit 1 transmitter empty = 1, bit 2 overflow = 0, bit 3 mode fault = 0), `rx_data_o` is 0, and both interrupt outputs are low.
- R2: A `rx_done_i` strobe while receiver full is 0 sets status bit 0 and loads `rx_byte_i` into `rx_data_o` on that clock edge.
- R3: Receiver full clears only when a status read (read with `bus_sel_i` = 2'b01) seen while it is set is followed by a data read (read with `bus_sel_i` = 2'b10). A data read with no armed status read leaves it set.
- R4: A `rx_done_i` between the arming status read and the data read cancels the arming, and receiver full stays set after that data read.
- R5: A `rx_done_i` while receiver full is set sets overflow (status bit 2) and leaves `rx_data_o` unchanged.
- R6: Overflow clears when a status read seen while it is set is followed by a data read. A new overflow event in the meantime cancels the arming.
- R7: Transmitter empty (status bit 1) clears on any write with `bus_sel_i` = 2'b10 and sets on `tx_load_i`. When both fall in the same cycle, the write wins and the flag ends at 0.
- R8: Mode fault (status bit 3) is set by `modf_det_i` only while `modf_en_i` is 1. It clears when a status read seen while it is set is followed by a write with `bus_sel_i` = 2'b00.
- R9: `irq_tx_o` is high exactly one clock after transmitter empty, `tx_ie_i` and `spi_en_i` are all 1.
- R10: `irq_rxerr_o` is high one clock after (receiver full and `rx_ie_i`) or (`err_ie_i` and (overflow or mode fault)), whatever the value of `spi_en_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_rd_i | input | 1 | Register read strobe |
| bus_wr_i | input | 1 | Register write strobe |
| bus_sel_i | input | 2 | Register select: 00 control, 01 status, 10 data |
| rx_done_i | input | 1 | Shift engine received a byte |
| rx_byte_i | input | DW | Byte delivered with rx_done_i |
| tx_load_i | input | 1 | Transmit byte moved into the shifter |
| modf_det_i | input | 1 | Mode fault detected |
| spi_en_i | input | 1 | Peripheral enable |
| tx_ie_i | input | 1 | Transmit interrupt enable |
| rx_ie_i | input | 1 | Receive interrupt enable |
| err_ie_i | input | 1 | Error interrupt enable |
| modf_en_i | input | 1 | Mode-fault recording enable |
| status_o | output | 4 | Flags {mode fault, overflow, tx empty, rx full} |
| rx_data_o | output | DW | Receive data register |
| irq_tx_o | output | 1 | Transmitter interrupt request |
| irq_rxerr_o | output | 1 | Receiver/error interrupt request |

## Verification
The case that matters most is a byte arrival in the same cycle as the data read that would finish a receiver-full clear. Under the required priority, the arrival wins: the flag stays set, overflow is raised and the held byte is kept. Random stimulus makes reads and arrival strobes overlap often, and a directed step forces the collision once. A bench reference model that applies the same priority judges every cycle. The transmit-empty flag gets the same treatment when a data write and a shifter load fall together.

// File: rtl/spi_flag_pkg.sv
// Shared definitions for the SPI flag controller: register select codes
// and bit positions of the flags in the status vector.
package spi_flag_pkg;
    typedef enum logic [1:0] {
        SEL_CTRL = 2'b00,
        SEL_STAT = 2'b01,
        SEL_DATA = 2'b10,
        SEL_NONE = 2'b11
    } reg_sel_e;

    localparam int ST_W   = 4;
    localparam int ST_RXF = 0;
    localparam int ST_TXE = 1;
    localparam int ST_OVR = 2;
    localparam int ST_MDF = 3;
endpackage

// File: rtl/spi_rx_flags.sv
// Receiver-full and overflow flags with the receive data register.
// Assumes at most one bus access per cycle. An arrival always wins over a
// clearing read in the same cycle.
module spi_rx_flags #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rx_done_i,
    input  logic [DW-1:0] rx_byte_i,
    input  logic          stat_rd_i,
    input  logic          data_rd_i,
    output logic          rxf_o,
    output logic          ovr_o,
    output logic [DW-1:0] rx_data_o
);
    logic          rxf_q, ovr_q, rx_arm_q, ov_arm_q;
    logic [DW-1:0] data_q;
    logic          ovf_ev;

    assign ovf_ev = rx_done_i && rxf_q;

    // Receiver-full flag and data capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rxf_q  <= 1'b0;
            data_q <= '0;
        end else if (rx_done_i) begin
            if (!rxf_q) begin
                rxf_q  <= 1'b1;
                data_q <= rx_byte_i;
            end
        end else if (data_rd_i && rx_arm_q) begin
            rxf_q <= 1'b0;
        end
    end

    // Arm state for the receiver-full clear sequence.
    always_ff @(posedge clk) begin
        if (!rst_n)                       rx_arm_q <= 1'b0;
        else if (rx_done_i || data_rd_i)  rx_arm_q <= 1'b0;
        else if (stat_rd_i && rxf_q)      rx_arm_q <= 1'b1;
    end

    // Overflow flag.
    always_ff @(posedge clk) begin
        if (!rst_n)                        ovr_q <= 1'b0;
        else if (ovf_ev)                   ovr_q <= 1'b1;
        else if (data_rd_i && ov_arm_q)    ovr_q <= 1'b0;
    end

    // Arm state for the overflow clear sequence.
    always_ff @(posedge clk) begin
        if (!rst_n)                       ov_arm_q <= 1'b0;
        else if (ovf_ev || data_rd_i)     ov_arm_q <= 1'b0;
        else if (stat_rd_i && ovr_q)      ov_arm_q <= 1'b1;
    end

    assign rxf_o     = rxf_q;
    assign ovr_o     = ovr_q;
    assign rx_data_o = data_q;

    assert_arrival_sets_rxf_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rx_done_i |=> rxf_q);
    assert_ovf_keeps_data_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_done_i && rxf_q) |=> (ovr_q && data_q == $past(data_q)));
    assert_rxf_clears_on_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rxf_q) |-> $past(data_rd_i));
    assert_ovr_clears_on_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ovr_q) |-> $past(data_rd_i));
endmodule

// File: rtl/spi_tx_flag.sv
// Transmitter-empty flag: set when the shifter takes the byte, cleared by
// any transmit data write. A write wins over a simultaneous load.
module spi_tx_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic tx_load_i,
    input  logic data_wr_i,
    output logic txe_o
);
    logic txe_q;

    // Empty flag update, reset to empty.
    always_ff @(posedge clk) begin
        if (!rst_n)          txe_q <= 1'b1;
        else if (data_wr_i)  txe_q <= 1'b0;
        else if (tx_load_i)  txe_q <= 1'b1;
    end

    assign txe_o = txe_q;

    assert_write_empties_R7: assert property (@(posedge clk) disable iff (!rst_n)
        data_wr_i |=> !txe_q);
    assert_load_sets_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_load_i && !data_wr_i) |=> txe_q);
endmodule

// File: rtl/spi_modf_flag.sv
// Mode-fault flag. Detection is recorded only while recording is enabled.
// Cleared by a status read with the flag set followed by a control write.
module spi_modf_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic modf_det_i,
    input  logic modf_en_i,
    input  logic stat_rd_i,
    input  logic ctrl_wr_i,
    output logic mdf_o
);
    logic mdf_q, md_arm_q, set_ev;

    assign set_ev = modf_det_i && modf_en_i;

    // Fault flag update.
    always_ff @(posedge clk) begin
        if (!rst_n)                     mdf_q <= 1'b0;
        else if (set_ev)                mdf_q <= 1'b1;
        else if (ctrl_wr_i && md_arm_q) mdf_q <= 1'b0;
    end

    // Arm state for the fault clear sequence.
    always_ff @(posedge clk) begin
        if (!rst_n)                    md_arm_q <= 1'b0;
        else if (set_ev || ctrl_wr_i)  md_arm_q <= 1'b0;
        else if (stat_rd_i && mdf_q)   md_arm_q <= 1'b1;
    end

    assign mdf_o = mdf_q;

    assert_fault_needs_enable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mdf_q) |-> $past(modf_en_i));
    assert_fault_clear_by_ctrl_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mdf_q) |-> $past(ctrl_wr_i));
endmodule

// File: rtl/spi_irq_gen.sv
// Registered interrupt requests. The transmit line is gated by the
// peripheral enable; the receive/error line is not.
module spi_irq_gen (
    input  logic clk,
    input  logic rst_n,
    input  logic rxf_i,
    input  logic txe_i,
    input  logic ovr_i,
    input  logic mdf_i,
    input  logic spi_en_i,
    input  logic tx_ie_i,
    input  logic rx_ie_i,
    input  logic err_ie_i,
    output logic irq_tx_o,
    output logic irq_rxerr_o
);
    logic err_any;

    assign err_any = ovr_i || mdf_i;

    // Register both request lines.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_tx_o    <= 1'b0;
            irq_rxerr_o <= 1'b0;
        end else begin
            irq_tx_o    <= txe_i && tx_ie_i && spi_en_i;
            irq_rxerr_o <= (rxf_i && rx_ie_i) || (err_ie_i && err_any);
        end
    end

    assert_tx_needs_enable_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_tx_o |-> $past(spi_en_i));
    assert_rxerr_needs_source_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(rx_ie_i) && !$past(err_ie_i)) |-> !irq_rxerr_o);
endmodule

// File: rtl/spi_flag_irq.sv
// Top of the SPI flag and interrupt controller. Decodes bus strobes into
// status read, data read, data write and control write, and joins the
// flag units and the interrupt generator. One bus access per cycle assumed.
module spi_flag_irq
    import spi_flag_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_rd_i,
    input  logic          bus_wr_i,
    input  logic [1:0]    bus_sel_i,
    input  logic          rx_done_i,
    input  logic [DW-1:0] rx_byte_i,
    input  logic          tx_load_i,
    input  logic          modf_det_i,
    input  logic          spi_en_i,
    input  logic          tx_ie_i,
    input  logic          rx_ie_i,
    input  logic          err_ie_i,
    input  logic          modf_en_i,
    output logic [3:0]    status_o,
    output logic [DW-1:0] rx_data_o,
    output logic          irq_tx_o,
    output logic          irq_rxerr_o
);
    reg_sel_e sel;
    logic     stat_rd, data_rd, data_wr, ctrl_wr;
    logic     rxf, txe, ovr, mdf;

    // Access decode.
    always_comb begin
        sel     = reg_sel_e'(bus_sel_i);
        stat_rd = bus_rd_i && (sel == SEL_STAT);
        data_rd = bus_rd_i && (sel == SEL_DATA);
        data_wr = bus_wr_i && (sel == SEL_DATA);
        ctrl_wr = bus_wr_i && (sel == SEL_CTRL);
    end

    spi_rx_flags #(.DW(DW)) u_rx (
        .clk(clk), .rst_n(rst_n), .rx_done_i(rx_done_i), .rx_byte_i(rx_byte_i),
        .stat_rd_i(stat_rd), .data_rd_i(data_rd),
        .rxf_o(rxf), .ovr_o(ovr), .rx_data_o(rx_data_o)
    );

    spi_tx_flag u_tx (
        .clk(clk), .rst_n(rst_n), .tx_load_i(tx_load_i), .data_wr_i(data_wr),
        .txe_o(txe)
    );

    spi_modf_flag u_mdf (
        .clk(clk), .rst_n(rst_n), .modf_det_i(modf_det_i), .modf_en_i(modf_en_i),
        .stat_rd_i(stat_rd), .ctrl_wr_i(ctrl_wr), .mdf_o(mdf)
    );

    spi_irq_gen u_irq (
        .clk(clk), .rst_n(rst_n), .rxf_i(rxf), .txe_i(txe), .ovr_i(ovr), .mdf_i(mdf),
        .spi_en_i(spi_en_i), .tx_ie_i(tx_ie_i), .rx_ie_i(rx_ie_i), .err_ie_i(err_ie_i),
        .irq_tx_o(irq_tx_o), .irq_rxerr_o(irq_rxerr_o)
    );

    // Status vector packing.
    always_comb begin
        status_o         = '0;
        status_o[ST_RXF] = rxf;
        status_o[ST_TXE] = txe;
        status_o[ST_OVR] = ovr;
        status_o[ST_MDF] = mdf;
    end

    assert_reset_state_R1: assert property (@(posedge clk)
        !rst_n |=> (status_o == 4'b0010 && !irq_tx_o && !irq_rxerr_o));
endmodule

// File: tb/spi_flag_irq_test.sv
// Self-checking bench: directed corner cases, then seeded random traffic,
// all judged against a bench reference model.
module spi_flag_irq_test;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          rd = 0, wr = 0;
    logic [1:0]    sel = 2'b11;
    logic          rx_done = 0, tx_load = 0, modf_det = 0;
    logic [DW-1:0] rx_byte = '0;
    logic          spi_en = 0, tx_ie = 0, rx_ie = 0, err_ie = 0, modf_en = 0;
    logic [3:0]    status;
    logic [DW-1:0] rx_data;
    logic          irq_tx, irq_rxerr;

    int n_chk = 0;
    int n_bad = 0;

    // Reference model state.
    logic m_rxf, m_txe, m_ovr, m_mdf, m_rarm, m_oarm, m_marm, m_itx, m_ire;
    logic [DW-1:0] m_data;

    always #5 clk = ~clk;

    spi_flag_irq #(.DW(DW)) uut (
        .clk(clk), .rst_n(rst_n), .bus_rd_i(rd), .bus_wr_i(wr), .bus_sel_i(sel),
        .rx_done_i(rx_done), .rx_byte_i(rx_byte), .tx_load_i(tx_load),
        .modf_det_i(modf_det), .spi_en_i(spi_en), .tx_ie_i(tx_ie), .rx_ie_i(rx_ie),
        .err_ie_i(err_ie), .modf_en_i(modf_en), .status_o(status), .rx_data_o(rx_data),
        .irq_tx_o(irq_tx), .irq_rxerr_o(irq_rxerr)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        m_rxf = 0; m_txe = 1; m_ovr = 0; m_mdf = 0;
        m_rarm = 0; m_oarm = 0; m_marm = 0; m_itx = 0; m_ire = 0; m_data = '0;
    endtask

    // One clock edge of the reference model, from the requirements.
    task automatic model_step();
        logic srd, drd, dwr, cwr, ovf, mset;
        logic n_rxf, n_ovr, n_txe, n_mdf, n_rarm, n_oarm, n_marm;
        logic [DW-1:0] n_data;
        srd = rd && sel == 2'b01;
        drd = rd && sel == 2'b10;
        dwr = wr && sel == 2'b10;
        cwr = wr && sel == 2'b00;
        ovf = rx_done && m_rxf;
        mset = modf_det && modf_en;
        n_rxf = m_rxf; n_data = m_data;
        if (rx_done) begin
            if (!m_rxf) begin n_rxf = 1; n_data = rx_byte; end
        end else if (drd && m_rarm) n_rxf = 0;
        n_rarm = (rx_done || drd) ? 1'b0 : ((srd && m_rxf) ? 1'b1 : m_rarm);
        n_ovr = ovf ? 1'b1 : ((drd && m_oarm) ? 1'b0 : m_ovr);
        n_oarm = (ovf || drd) ? 1'b0 : ((srd && m_ovr) ? 1'b1 : m_oarm);
        n_txe = dwr ? 1'b0 : (tx_load ? 1'b1 : m_txe);
        n_mdf = mset ? 1'b1 : ((cwr && m_marm) ? 1'b0 : m_mdf);
        n_marm = (mset || cwr) ? 1'b0 : ((srd && m_mdf) ? 1'b1 : m_marm);
        m_itx = m_txe && tx_ie && spi_en;
        m_ire = (m_rxf && rx_ie) || (err_ie && (m_ovr || m_mdf));
        m_rxf = n_rxf; m_data = n_data; m_rarm = n_rarm; m_ovr = n_ovr; m_oarm = n_oarm;
        m_txe = n_txe; m_mdf = n_mdf; m_marm = n_marm;
    endtask

    task automatic compare_all();
        check("R3 rx full",    status[0], m_rxf);
        check("R7 tx empty",   status[1], m_txe);
        check("R6 overflow",   status[2], m_ovr);
        check("R8 mode fault", status[3], m_mdf);
        check("R5 rx data",    rx_data, m_data);
        check("R9 irq tx",     irq_tx, m_itx);
        check("R10 irq rxerr", irq_rxerr, m_ire);
    endtask

    // Apply current inputs for one edge, then clear strobes at the negedge.
    task automatic cycle();
        @(posedge clk);
        model_step();
        #1 compare_all();
        @(negedge clk);
        rd = 0; wr = 0; sel = 2'b11; rx_done = 0; tx_load = 0; modf_det = 0;
    endtask

    task automatic acc(input logic r, input logic [1:0] s);
        rd = r; wr = !r; sel = s;
        cycle();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL R1 watchdog actual=timeout expected=finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        // R1 reset state
        check("R1 status", status, 4'b0010);
        check("R1 data", rx_data, 0);
        check("R1 irqs", {irq_tx, irq_rxerr}, 2'b00);

        // R2 first byte
        rx_done = 1; rx_byte = 8'hA5; cycle();
        check("R2 rxf set", status[0], 1); check("R2 data", rx_data, 8'hA5);
        // R4 arm then arrival (also overflow R5), then data read
        acc(1, 2'b01);
        rx_done = 1; rx_byte = 8'h3C; cycle();
        check("R5 overflow", status[2], 1); check("R5 data kept", rx_data, 8'hA5);
        acc(1, 2'b10);
        check("R4 rxf kept", status[0], 1);
        // R3/R6 full clear sequence
        acc(1, 2'b01); acc(1, 2'b10);
        check("R3 rxf cleared", status[0], 0);
        check("R6 ovr cleared", status[2], 0);
        // R3 unarmed data read does nothing
        rx_done = 1; rx_byte = 8'h11; cycle();
        acc(1, 2'b10);
        check("R3 unarmed read", status[0], 1);
        // Collision: arming read done, arrival with the data read
        acc(1, 2'b01);
        rd = 1; sel = 2'b10; rx_done = 1; rx_byte = 8'h77; cycle();
        check("R4 collision rxf", status[0], 1);
        check("R5 collision data", rx_data, 8'h11);
        acc(1, 2'b01); acc(1, 2'b10);

        // R7 transmit flag
        acc(0, 2'b10); check("R7 write clears", status[1], 0);
        tx_load = 1; cycle(); check("R7 load sets", status[1], 1);
        tx_load = 1; wr = 1; sel = 2'b10; cycle(); check("R7 write wins", status[1], 0);
        tx_load = 1; cycle();

        // R8 mode fault
        modf_en = 0; modf_det = 1; cycle(); check("R8 held off", status[3], 0);
        modf_en = 1; modf_det = 1; cycle(); check("R8 set", status[3], 1);
        acc(0, 2'b00); check("R8 unarmed ctrl write", status[3], 1);
        acc(1, 2'b01); acc(0, 2'b00); check("R8 cleared", status[3], 0);

        // R9 transmit gating
        tx_ie = 1; spi_en = 0; cycle(); cycle(); check("R9 gated by enable", irq_tx, 0);
        spi_en = 1; cycle(); check("R9 raised", irq_tx, 1);
        // R10 receive ignores enable
        spi_en = 0; rx_ie = 1; rx_done = 1; rx_byte = 8'h5A; cycle(); cycle();
        check("R10 rx irq without enable", irq_rxerr, 1);
        rx_ie = 0; err_ie = 1; modf_det = 1; cycle(); cycle();
        check("R10 error irq", irq_rxerr, 1);

        // Random traffic
        for (int i = 0; i < 4000; i++) begin
            int op;
            op = $urandom_range(0, 6);
            case (op)
                0, 1: begin rd = 1; sel = 2'b01; end
                2:    begin rd = 1; sel = 2'b10; end
                3:    begin wr = 1; sel = 2'b10; end
                4:    begin wr = 1; sel = 2'b00; end
                default: ;
            endcase
            rx_done  = ($urandom_range(0, 3) == 0);
            rx_byte  = DW'($urandom);
            tx_load  = ($urandom_range(0, 5) == 0);
            modf_det = ($urandom_range(0, 7) == 0);
            if ($urandom_range(0, 15) == 0) spi_en  = ~spi_en;
            if ($urandom_range(0, 15) == 0) tx_ie   = ~tx_ie;
            if ($urandom_range(0, 15) == 0) rx_ie   = ~rx_ie;
            if ($urandom_range(0, 15) == 0) err_ie  = ~err_ie;
            if ($urandom_range(0, 15) == 0) modf_en = ~modf_en;
            cycle();
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule